// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the fault confinement state of one CAN node. A receive counter (8 bits) and a transmit counter (9 bits) move in response to single-cycle event strobes from the protocol engine. Errors raise a counter by 1 or by 8, depending on severity. Successful frames lower it. From the two counters the block derives three flags: error warning, error passive and bus-off.

It also keeps a 3-bit code that names the most recent error. All of this is gathered into one 32-bit status word for software to read. While the node is in bus-off, both counters are frozen. A recovery request then returns the node to the error-active state with both counters at zero.

Counting of the recovery sequence and all bit-level framing stay in the surrounding controller. This block only reacts to the strobes it is given.

Top module: `can_fault_ctr`

## Requirements
- R1: A receive error adds 1 to the receive counter, or 8 when `rx_err_severe_i` is high. The counter saturates at 255.
- R2: A successful reception loads 120 when the receive counter is above 128. Otherwise it subtracts 1, and a value of 0 stays 0.
- R3: A transmit error adds 1 to the transmit counter, or 8 when `tx_err_severe_i` is high. A successful transmission subtracts 1, and a value of 0 stays 0.
- R4: When an error strobe and a success strobe for the same counter arrive in the same cycle, only the error is applied.
- R5: `warn_o` is high while either counter is 96 or more.
- R6: `passive_o` is high while either counter is above 127.
- R7: `busoff_o` is high while the transmit counter is above 255. In that state all receive and transmit strobes are ignored, and both counters hold.
- R8: A `recover_i` pulse during bus-off clears both counters, which ends bus-off. Outside bus-off the pulse has no effect.
- R9: The status word layout is fixed:
  - bits 31:24 hold the receive counter;
  - bits 23:16 hold the low 8 bits of the transmit counter;
  - bits 15:7 and bit 3 read 0;
  - bits 6:4 hold the last-error code;
  - bit 2 is bus-off, bit 1 is error passive and bit 0 is error warning.
- R10: Any accepted error strobe (receive or transmit) loads `err_code_i` into the last-error code. `lec_clr_i` clears the code to 0, and an error strobe in the same cycle wins over the clear.
- R11: After reset, the counters, the flags and the whole status word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_err_i | input | 1 | Receive error strobe |
| rx_err_severe_i | input | 1 | Receive error is severe (add 8) |
| rx_ok_i | input | 1 | Successful reception strobe |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_err_severe_i | input | 1 | Transmit error is severe (add 8) |
| tx_ok_i | input | 1 | Successful transmission strobe |
| recover_i | input | 1 | Bus-off recovery request |
| err_code_i | input | 3 | Error type that goes with an error strobe |
| lec_clr_i | input | 1 | Software clear of the last-error code |
| rec_o | output | 8 | Receive error counter |
| tec_o | output | 9 | Transmit error counter |
| warn_o | output | 1 | Error warning flag |
| passive_o | output | 1 | Error passive flag |
| busoff_o | output | 1 | Bus-off flag |
| status_o | output | 32 | Packed status word |

## Verification
The assertions check the following on every cycle:
- the single-step rise and the saturation of the receive counter;
- the reload to 120;
- the floor of the transmit counter at zero;
- that bus-off freezes both counters, and that recovery clears them;
- that a software clear of the error code takes effect;
- that an error strobe wins over a success strobe.

Only the bench's scenarios can show where the flag thresholds sit and the exact bit placement in the status word. They also show the 9-bit transmit counter reaching 256 while its visible byte reads zero, and the error code surviving a clear in the same cycle.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam int unsigned REC_W        = 8;
  localparam int unsigned TEC_W        = 9;
  localparam int unsigned CODE_W       = 3;
  localparam int unsigned SEVERE_STEP  = 8;
  localparam int unsigned RX_RELOAD    = 120;
  localparam int unsigned RX_RELOAD_GT = 128;
  localparam int unsigned WARN_LVL     = 96;
  localparam int unsigned PASSIVE_GT   = 127;
  localparam int unsigned BUSOFF_GT    = 255;

  typedef struct packed {
    logic err;
    logic severe;
    logic ok;
  } ctr_evt_t;
endpackage

// File: rtl/can_err_ctr.sv
module can_err_ctr #(
  parameter int unsigned W         = 8,
  parameter int unsigned STEP_BIG  = 8,
  parameter bit          RELOAD_EN = 1'b0,
  parameter int unsigned RELOAD_GT = 128,
  parameter int unsigned RELOAD_V  = 120
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  can_fault_pkg::ctr_evt_t   evt_i,
  input  logic                      hold_i,
  input  logic                      clear_i,
  output logic [W-1:0]              cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, dec_v;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + (evt_i.severe ? (W+1)'(STEP_BIG) : (W+1)'(1));

  generate
    if (RELOAD_EN) begin : g_reload
      always_comb begin
        if (cnt_q > W'(RELOAD_GT))  dec_v = W'(RELOAD_V);
        else if (cnt_q != '0)       dec_v = cnt_q - W'(1);
        else                        dec_v = '0;
      end
    end else begin : g_plain
      assign dec_v = (cnt_q != '0) ? cnt_q - W'(1) : '0;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)            cnt_d = '0;
    else if (!hold_i) begin
      if (evt_i.err)        cnt_d = sum[W] ? CNT_MAX : sum[W-1:0];
      else if (evt_i.ok)    cnt_d = dec_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/can_fault_stat.sv
module can_fault_stat #(
  parameter int unsigned REC_W  = 8,
  parameter int unsigned TEC_W  = 9,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REC_W-1:0]  rec_i,
  input  logic [TEC_W-1:0]  tec_i,
  input  logic              err_evt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic              warn_o,
  output logic              passive_o,
  output logic              busoff_o,
  output logic [31:0]       status_o
);
  import can_fault_pkg::*;

  localparam int unsigned RSVD_W = 16 - CODE_W - 4;

  logic [CODE_W-1:0] lec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lec_q <= '0;
    else if (err_evt_i) lec_q <= code_i;
    else if (clr_i)     lec_q <= '0;
  end

  assign warn_o    = (rec_i >= REC_W'(WARN_LVL)) || (tec_i >= TEC_W'(WARN_LVL));
  assign passive_o = (rec_i > REC_W'(PASSIVE_GT)) || (tec_i > TEC_W'(PASSIVE_GT));
  assign busoff_o  = tec_i > TEC_W'(BUSOFF_GT);

  assign status_o = {rec_i, tec_i[7:0], {RSVD_W{1'b0}}, lec_q, 1'b0,
                     busoff_o, passive_o, warn_o};
endmodule

// File: rtl/can_fault_ctr.sv
module can_fault_ctr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_err_i,
  input  logic        rx_err_severe_i,
  input  logic        rx_ok_i,
  input  logic        tx_err_i,
  input  logic        tx_err_severe_i,
  input  logic        tx_ok_i,
  input  logic        recover_i,
  input  logic [2:0]  err_code_i,
  input  logic        lec_clr_i,
  output logic [7:0]  rec_o,
  output logic [8:0]  tec_o,
  output logic        warn_o,
  output logic        passive_o,
  output logic        busoff_o,
  output logic [31:0] status_o
);
  import can_fault_pkg::*;

  ctr_evt_t rx_evt, tx_evt;
  logic     busoff, clear, err_evt;

  assign rx_evt  = '{err: rx_err_i, severe: rx_err_severe_i, ok: rx_ok_i};
  assign tx_evt  = '{err: tx_err_i, severe: tx_err_severe_i, ok: tx_ok_i};
  assign clear   = recover_i & busoff;
  // strobes during bus-off are dropped, so they must not touch the code either
  assign err_evt = (rx_err_i | tx_err_i) & ~busoff;

  can_err_ctr #(
    .W(REC_W), .STEP_BIG(SEVERE_STEP), .RELOAD_EN(1'b1),
    .RELOAD_GT(RX_RELOAD_GT), .RELOAD_V(RX_RELOAD)
  ) rx_ctr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(rx_evt),
    .hold_i(busoff), .clear_i(clear), .cnt_o(rec_o)
  );

  can_err_ctr #(
    .W(TEC_W), .STEP_BIG(SEVERE_STEP), .RELOAD_EN(1'b0),
    .RELOAD_GT(0), .RELOAD_V(0)
  ) tx_ctr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(tx_evt),
    .hold_i(busoff), .clear_i(clear), .cnt_o(tec_o)
  );

  can_fault_stat #(
    .REC_W(REC_W), .TEC_W(TEC_W), .CODE_W(CODE_W)
  ) stat_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rec_i(rec_o), .tec_i(tec_o),
    .err_evt_i(err_evt), .code_i(err_code_i), .clr_i(lec_clr_i),
    .warn_o(warn_o), .passive_o(passive_o), .busoff_o(busoff),
    .status_o(status_o)
  );

  assign busoff_o = busoff;
endmodule

// File: rtl/can_fault_ctr_chk.sv
module can_fault_ctr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_err_i,
  input logic        rx_err_severe_i,
  input logic        rx_ok_i,
  input logic        tx_err_i,
  input logic        tx_ok_i,
  input logic        recover_i,
  input logic        lec_clr_i,
  input logic [7:0]  rec_o,
  input logic [8:0]  tec_o,
  input logic        busoff_o,
  input logic [31:0] status_o
);
  assert_rx_minor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i && !rx_err_severe_i && !busoff_o && rec_o != 8'hFF |=> rec_o == $past(rec_o) + 8'd1);

  assert_rx_sat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i && !busoff_o && rec_o == 8'hFF |=> rec_o == 8'hFF);

  assert_rx_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_i && !rx_err_i && !busoff_o && rec_o > 8'd128 |=> rec_o == 8'd120);

  assert_tx_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_i && !tx_err_i && !busoff_o && tec_o == 9'd0 |=> tec_o == 9'd0);

  assert_err_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i && rx_ok_i && !busoff_o && rec_o < 8'd200 |=> rec_o > $past(rec_o));

  assert_busoff_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o && !recover_i |=> $stable(tec_o) && $stable(rec_o));

  assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o && recover_i |=> rec_o == 8'd0 && tec_o == 9'd0 && !busoff_o);

  assert_lec_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lec_clr_i && !rx_err_i && !tx_err_i |=> status_o[6:4] == 3'd0);
endmodule

bind can_fault_ctr can_fault_ctr_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_err_i(rx_err_i),
  .rx_err_severe_i(rx_err_severe_i), .rx_ok_i(rx_ok_i),
  .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i), .recover_i(recover_i),
  .lec_clr_i(lec_clr_i), .rec_o(rec_o), .tec_o(tec_o),
  .busoff_o(busoff_o), .status_o(status_o)
);

// File: tb/can_fault_ctr_tb.sv
`timescale 1ns/1ps
module can_fault_ctr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_err = 0, rx_sev = 0, rx_ok = 0, tx_err = 0, tx_sev = 0, tx_ok = 0, recover = 0;
  logic [2:0] code = '0;
  logic clr = 0;
  logic [7:0] rec;
  logic [8:0] tec;
  logic warn, passive, busoff;
  logic [31:0] status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_fault_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_err_i(rx_err), .rx_err_severe_i(rx_sev),
    .rx_ok_i(rx_ok), .tx_err_i(tx_err), .tx_err_severe_i(tx_sev), .tx_ok_i(tx_ok),
    .recover_i(recover), .err_code_i(code), .lec_clr_i(clr), .rec_o(rec),
    .tec_o(tec), .warn_o(warn), .passive_o(passive), .busoff_o(busoff),
    .status_o(status)
  );

  // {rx_err, rx_sev, rx_ok, tx_err, tx_sev, tx_ok, recover, exp_rec[8], exp_tec[9]}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {7'b1000000, 8'd1, 9'd0},
    {7'b1100000, 8'd9, 9'd0},
    {7'b0010000, 8'd8, 9'd0},
    {7'b0001100, 8'd8, 9'd8},
    {7'b0001000, 8'd8, 9'd9},
    {7'b0000010, 8'd8, 9'd8},
    {7'b1010000, 8'd9, 9'd8},
    {7'b0001110, 8'd9, 9'd16},
    {7'b0010010, 8'd8, 9'd15},
    {7'b0000001, 8'd8, 9'd15}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] s, input logic [2:0] c, input logic cl);
    @(negedge clk);
    {rx_err, rx_sev, rx_ok, tx_err, tx_sev, tx_ok, recover} = s;
    code = c; clr = cl;
    @(negedge clk);
    {rx_err, rx_sev, rx_ok, tx_err, tx_sev, tx_ok, recover} = '0;
    code = '0; clr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check(status == 32'h0 && rec == 0 && tec == 0, "R11 reset", status, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:17], 3'd1, 1'b0);
      check(rec == VEC[i][16:9], $sformatf("R1/R2/R4/R8 vec%0d rec", i), 32'(rec), 32'(VEC[i][16:9]));
      check(tec == VEC[i][8:0], $sformatf("R3/R4 vec%0d tec", i), 32'(tec), 32'(VEC[i][8:0]));
    end

    // R5/R6 receive thresholds and R2 reload
    do_reset();
    for (int i = 0; i < 11; i++) step(7'b1100000, 3'd1, 0);
    check(rec == 88 && !warn, "R5 rec 88 no warn", 32'(warn), 32'h0);
    step(7'b1100000, 3'd1, 0);
    check(rec == 96 && warn && !passive, "R5 rec 96 warn", {rec, 7'b0, warn}, {8'd96, 7'b0, 1'b1});
    for (int i = 0; i < 4; i++) step(7'b1100000, 3'd1, 0);
    check(rec == 128 && passive, "R6 rec 128 passive", {rec, 7'b0, passive}, {8'd128, 7'b0, 1'b1});
    step(7'b0010000, 3'd0, 0);
    check(rec == 127 && !passive, "R2 128 decrements", 32'(rec), 32'd127);
    step(7'b1100000, 3'd1, 0); step(7'b1100000, 3'd1, 0);
    step(7'b0010000, 3'd0, 0);
    check(rec == 120, "R2 reload from 143", 32'(rec), 32'd120);
    for (int i = 0; i < 20; i++) step(7'b1100000, 3'd1, 0);
    step(7'b1000000, 3'd1, 0);
    check(rec == 255, "R1 saturate", 32'(rec), 32'd255);
    step(7'b0010000, 3'd0, 0);
    check(rec == 120, "R2 reload from 255", 32'(rec), 32'd120);

    // R2/R3 floors
    do_reset();
    step(7'b0010010, 3'd0, 0);
    check(rec == 0 && tec == 0, "R2/R3 floor at zero", {rec, 15'b0, tec}, 32'h0);

    // R10 last-error code and R9 layout
    step(7'b1000000, 3'd5, 0);
    check(status == 32'h0100_0050, "R9/R10 code 5", status, 32'h0100_0050);
    step(7'b0000000, 3'd0, 1);
    check(status == 32'h0100_0000, "R10 clear", status, 32'h0100_0000);
    step(7'b1000000, 3'd2, 1);
    check(status == 32'h0200_0020, "R10 error wins clear", status, 32'h0200_0020);
    step(7'b0001100, 3'd6, 0);
    check(status == 32'h0208_0060, "R10 tx code", status, 32'h0208_0060);

    // R5/R7/R8 transmit path to bus-off
    do_reset();
    for (int i = 0; i < 3; i++) step(7'b1000000, 3'd1, 0);
    for (int i = 0; i < 12; i++) step(7'b0001100, 3'd1, 0);
    check(tec == 96 && warn, "R5 tec 96 warn", 32'(tec), 32'd96);
    for (int i = 0; i < 20; i++) step(7'b0001100, 3'd1, 0);
    check(tec == 256 && busoff, "R7 busoff at 256", 32'(tec), 32'd256);
    check(status == 32'h0300_0017, "R9 busoff status", status, 32'h0300_0017);
    step(7'b1101110, 3'd4, 0);
    check(tec == 256 && rec == 3 && status[6:4] == 3'd1, "R7 strobes ignored",
          {rec, 7'b0, tec, 5'b0, status[6:4]}, {8'd3, 7'b0, 9'd256, 5'b0, 3'd1});
    step(7'b0000001, 3'd0, 0);
    check(tec == 0 && rec == 0 && !busoff, "R8 recover", {rec, 15'b0, tec}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule